// File: doc/BRIEF.md
# Multi-Mode Lookup Cell

This block is a sixteen-bit storage array that serves three purposes, picked by a two-bit mode input. As a function generator it returns any Boolean function of four inputs. The four select bits index a stored truth table, and that table is written in one cycle through a parallel preload port. As a small memory it becomes a 16-entry, 1-bit-wide RAM. Writes happen on the clock edge and reads are combinational. As a delay line it becomes a sixteen-stage shift register whose stage can be picked through the same four select bits.

The select bits always form the read address, with bit 3 as the most significant and bit 0 as the least significant. The output `q_o` shows the cell at that address in every mode. The last stage, cell 15, drives `chain_o` at all times, so several cells can be chained into a longer shift register.

Top module: `mlc_cell`

## Requirements
- R1: A synchronous active-high reset clears all sixteen cells, so after reset `q_o` is 0 at every address and `chain_o` is 0.
- R2: `q_o` equals cell k when `sel_i` holds the binary value k (bit 3 most significant). In lookup mode (`mode_i` = 2'b00) this realises the function whose truth-table row k is bit k of the preloaded word.
- R3: With `cfg_load_i` high, a rising edge copies all sixteen bits of `cfg_data_i` into the cells (bit k into cell k), and the new contents are visible from the next cycle.
- R4: A preload takes priority over a RAM write or a shift in the same cycle. The cells then hold exactly `cfg_data_i`.
- R5: In lookup mode, and in the unused mode 2'b11, clock edges with `we_i` high leave the contents unchanged. Only a preload changes them.
- R6: In RAM mode (`mode_i` = 2'b01), a rising edge with `we_i` high stores `din_i` into the addressed cell and changes no other cell.
- R7: In RAM mode the read is combinational. A new address shows its cell in the same cycle, and a written value shows from the cycle after the write edge.
- R8: In shift mode (`mode_i` = 2'b10), a rising edge with `we_i` high moves cell k into cell k+1 for k = 0..14 and loads `din_i` into cell 0. `q_o` shows the stage picked by `sel_i`.
- R9: `chain_o` always equals cell 15.
- R10: In shift mode with `we_i` low, the contents hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sel_i | input | 4 | Select/address, bit 3 most significant |
| cfg_load_i | input | 1 | Parallel preload strobe |
| cfg_data_i | input | 16 | Preload word, bit k to cell k |
| mode_i | input | 2 | 00 lookup, 01 RAM, 10 shift, 11 hold |
| din_i | input | 1 | Write or serial data in |
| we_i | input | 1 | Write/shift enable |
| q_o | output | 1 | Selected cell |
| chain_o | output | 1 | Cell 15, cascade output |

## Verification
The lookup function is checked with an asymmetric table (16'hA5C3) and a parity table (16'h6996). Both are swept over all sixteen addresses, which exposes swapped or reversed select bits. RAM mode writes to scattered addresses and reads all cells back, which separates a write to the wrong cell from a write that never lands. Shift mode runs an irregular serial pattern while the tap address varies, so a wrong shift direction or an off-by-one stage shows on both `q_o` and `chain_o`. Enable and preload are also held high in lookup mode and during a shift, to show that nothing leaks.

// File: rtl/mlc_pkg.sv
package mlc_pkg;
    localparam int SEL_W = 4;
    localparam int CELLS = 1 << SEL_W;

    typedef enum logic [1:0] {
        MODE_LOGIC = 2'b00,
        MODE_RAM   = 2'b01,
        MODE_SHIFT = 2'b10,
        MODE_HOLD  = 2'b11
    } mode_e;

    function automatic logic mode_writes(input mode_e m);
        return (m == MODE_RAM) || (m == MODE_SHIFT);
    endfunction
endpackage

// File: rtl/mlc_store.sv
module mlc_store
    import mlc_pkg::*;
#(
    parameter int SW = SEL_W,
    localparam int N = 1 << SW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_load,
    input  logic [N-1:0]  cfg_data,
    input  mode_e         mode,
    input  logic [SW-1:0] addr,
    input  logic          din,
    input  logic          we,
    output logic [N-1:0]  cells
);
    logic [N-1:0] nxt;
    logic         upd;

    assign upd = we && mode_writes(mode);

    for (genvar k = 0; k < N; k++) begin : g_cell
        logic shift_in;
        if (k == 0) begin : g_head
            assign shift_in = din;
        end else begin : g_body
            assign shift_in = cells[k-1];
        end

        always_comb begin
            nxt[k] = cells[k];
            if (cfg_load)
                nxt[k] = cfg_data[k];
            else if (upd && mode == MODE_RAM && addr == SW'(k))
                nxt[k] = din;
            else if (upd && mode == MODE_SHIFT)
                nxt[k] = shift_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            cells <= '0;
        else
            cells <= nxt;
    end

    assert_cfg_load_R4: assert property (@(posedge clk) disable iff (rst)
        cfg_load |=> cells == $past(cfg_data));

    assert_logic_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (!cfg_load && (mode == MODE_LOGIC || mode == MODE_HOLD)) |=> $stable(cells));

    assert_ram_write_R6: assert property (@(posedge clk) disable iff (rst)
        (!cfg_load && mode == MODE_RAM && we) |=> cells[$past(addr)] == $past(din));

    assert_shift_step_R8: assert property (@(posedge clk) disable iff (rst)
        (!cfg_load && mode == MODE_SHIFT && we)
        |=> (cells[0] == $past(din)) && (cells[N-1:1] == $past(cells[N-2:0])));

    assert_shift_idle_R10: assert property (@(posedge clk) disable iff (rst)
        (!cfg_load && mode == MODE_SHIFT && !we) |=> $stable(cells));
endmodule

// File: rtl/mlc_tap.sv
module mlc_tap #(
    parameter int SW = 4,
    localparam int N = 1 << SW
) (
    input  logic [N-1:0]  cells,
    input  logic [SW-1:0] addr,
    output logic          q
);
    always_comb begin
        q = 1'b0;
        for (int k = 0; k < N; k++)
            if (addr == SW'(k)) q = cells[k];
    end
endmodule

// File: rtl/mlc_cell.sv
module mlc_cell
    import mlc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             cfg_load_i,
    input  logic [CELLS-1:0] cfg_data_i,
    input  logic [1:0]       mode_i,
    input  logic             din_i,
    input  logic             we_i,
    output logic             q_o,
    output logic             chain_o
);
    logic [CELLS-1:0] cells;
    mode_e            mode;

    assign mode = mode_e'(mode_i);

    mlc_store #(.SW(SEL_W)) u_store (
        .clk      (clk),
        .rst      (rst),
        .cfg_load (cfg_load_i),
        .cfg_data (cfg_data_i),
        .mode     (mode),
        .addr     (sel_i),
        .din      (din_i),
        .we       (we_i),
        .cells    (cells)
    );

    mlc_tap #(.SW(SEL_W)) u_tap (
        .cells (cells),
        .addr  (sel_i),
        .q     (q_o)
    );

    assign chain_o = cells[CELLS-1];

    assert_chain_after_shift_R9: assert property (@(posedge clk) disable iff (rst)
        (!cfg_load_i && mode == MODE_SHIFT && we_i) |=> chain_o == $past(cells[CELLS-2]));
endmodule

// File: tb/sim_mlc_cell.sv
`timescale 1ns/1ps
module sim_mlc_cell;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  sel_i = '0;
    logic        cfg_load_i = 1'b0;
    logic [15:0] cfg_data_i = '0;
    logic [1:0]  mode_i = 2'b00;
    logic        din_i = 1'b0;
    logic        we_i = 1'b0;
    logic        q_o, chain_o;

    always #2.5 clk = ~clk;

    mlc_cell u0 (
        .clk(clk), .rst(rst), .sel_i(sel_i), .cfg_load_i(cfg_load_i),
        .cfg_data_i(cfg_data_i), .mode_i(mode_i), .din_i(din_i),
        .we_i(we_i), .q_o(q_o), .chain_o(chain_o)
    );

    typedef struct {
        string req;
        logic  q;
        logic  ch;
    } exp_t;

    exp_t        sb[$];
    logic [15:0] model;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    task automatic step(input logic r, input logic ld, input logic [15:0] cd,
                        input logic [1:0] md, input logic [3:0] a,
                        input logic d, input logic w, input string req, input bit chk);
        exp_t e;
        @(negedge clk);
        rst = r; cfg_load_i = ld; cfg_data_i = cd; mode_i = md;
        sel_i = a; din_i = d; we_i = w;
        if (chk) begin
            e.req = req; e.q = model[a]; e.ch = model[15];
            sb.push_back(e);
        end
        if (r)                        model = '0;
        else if (ld)                  model = cd;
        else if (w && md == 2'b01)    model[a] = d;
        else if (w && md == 2'b10)    model = {model[14:0], d};
    endtask

    task automatic sweep(input logic [1:0] md, input string req);
        for (int k = 0; k < 16; k++)
            step(0, 0, 16'h0, md, 4'(k), 0, 0, req, 1);
    endtask

    initial begin : monitor
        forever begin
            @(negedge clk);
            #1;
            while (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                n_chk++;
                if (q_o !== e.q || chain_o !== e.ch) begin
                    n_bad++;
                    $display("FAIL %s: q=%b chain=%b expected q=%b chain=%b",
                             e.req, q_o, chain_o, e.q, e.ch);
                end
            end
        end
    end

    initial begin : driver
        logic [15:0] pat;
        model = 'x;
        step(1, 0, 16'h0, 2'b00, 4'd0, 0, 0, "R1", 0);
        step(1, 0, 16'h0, 2'b00, 4'd0, 0, 0, "R1", 0);
        sweep(2'b00, "R1 reset clear");
        // R3 / R4: preload while a shift is requested
        step(0, 1, 16'hA5C3, 2'b10, 4'd3, 1, 1, "R4 same cycle", 1);
        sweep(2'b00, "R2 R4 table A5C3");
        step(0, 1, 16'h6996, 2'b01, 4'd7, 1, 1, "R3 preload", 1);
        sweep(2'b00, "R2 parity table");
        // R5: enable in lookup and hold modes
        for (int k = 0; k < 16; k++)
            step(0, 0, 16'h0, 2'(k % 2 == 0 ? 0 : 3), 4'(k), ~model[k], 1, "R5 no write", 1);
        sweep(2'b00, "R5 contents kept");
        // R6 / R7: RAM writes then readback
        step(0, 1, 16'h0000, 2'b00, 4'd0, 0, 0, "R3", 1);
        step(0, 0, 16'h0, 2'b01, 4'd5, 1, 1, "R6 write 5", 1);
        step(0, 0, 16'h0, 2'b01, 4'd5, 0, 0, "R7 read after write", 1);
        step(0, 0, 16'h0, 2'b01, 4'd15, 1, 1, "R6 write 15", 1);
        step(0, 0, 16'h0, 2'b01, 4'd0, 1, 1, "R6 write 0", 1);
        step(0, 0, 16'h0, 2'b01, 4'd10, 1, 1, "R6 write 10", 1);
        step(0, 0, 16'h0, 2'b01, 4'd5, 0, 1, "R6 clear 5", 1);
        sweep(2'b01, "R7 RAM readback");
        // R8 / R9: shift with moving tap
        pat = 16'b1101_0011_1000_1011;
        for (int k = 0; k < 24; k++)
            step(0, 0, 16'h0, 2'b10, 4'((k * 7) % 16), pat[k % 16], 1, "R8 R9 shift", 1);
        for (int k = 0; k < 6; k++)
            step(0, 0, 16'h0, 2'b10, 4'(k * 3), ~pat[k], 0, "R10 idle", 1);
        sweep(2'b10, "R8 R10 taps");
        step(0, 0, 16'h0, 2'b00, 4'd0, 0, 0, "R9", 1);
        step(0, 0, 16'h0, 2'b00, 4'd0, 0, 0, "R9", 1);
        done = 1'b1;
        #3;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : watchdog
        #(5.0 * 20000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run not finished, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule